// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Block

This block holds the settings of a clock synthesizer's feedback and output dividers. Two paths write them. One is a parallel pin bus: a 9-bit feedback word and a 3-bit output code are taken when a load strobe goes high. The other is a three-wire serial port. It shifts a 14-bit word into a holding register, and a separate strobe then moves that word into the divider settings. The serial word also carries a 2-bit test-select field, and only the serial port can write that field.

The block also contains the output divider chain. The fast clock is a single clock, and the chain advances on per-cycle tick enables. A mode select decides whether the chain follows the synthesizer tick or the reference tick. The primary output toggles at a rate set by the output code. The secondary output runs at one sixteenth of the primary. Each output has a complement. A functional master reset holds the chain cleared and leaves the programmed settings in place. A test output shows one of four internal sources in serial mode and is held low in parallel mode. All strobe and serial inputs are sampled on `clk`, which runs much faster than they toggle.

Top module: `clksyn_divcfg`

## Requirements
- R1: One cycle after `par_load` is sampled rising, `cfg_m` and `cfg_n` equal the values `par_m` and `par_n` held at that rising sample. `cfg_t` is unchanged.
- R2: A rising `ser_clk` shifts `ser_dat` into a 14-bit register, most significant bit first. The transferred word maps bits 13:12 to `cfg_t`, bits 11:9 to `cfg_n` and bits 8:0 to `cfg_m`, so the last bit shifted lands in `cfg_m[0]`.
- R3: While `par_load` and `ser_load` are both high, the settings follow the shift register one cycle behind it. Once `ser_load` falls, the settings hold while shifting continues.
- R4: While `par_load` stays low, or stays high without a rise and with `ser_load` low, the settings do not change. This holds even when `par_m`, `par_n` or `ser_load` change.
- R5: Output codes 0 to 7 select ratios R of 2, 4, 8, 16, 1, 2, 4 and 8. `out0` toggles once every R ticks of the selected source.
- R6: `out1` toggles once per 16 toggles of `out0`, so its period is 16 times that of `out0`.
- R7: `out0_n` and `out1_n` are always the inverses of `out0` and `out1`.
- R8: From the cycle after `mreset` is sampled high, and while it stays high, `out0` and `out1` are low and their complements are high. The settings are kept. After release the chain divides again.
- R9: `pll_sel` high makes `vco_tick` drive the chain. Low makes `ref_tick` drive it.
- R10: When `par_load` is low, `test_out` is 0. When it is high, `cfg_t` selects the source: 00 gives the shift register's bit 0, 01 gives 1, 10 gives a flop that toggles on each `ref_tick`, and 11 gives `out1`.
- R11: While `rst_n` is low, all settings are zero, `out0` and `out1` are 0, their complements are 1, and `test_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; samples every input |
| rst_n | input | 1 | Synchronous active-low reset |
| par_load | input | 1 | Parallel load strobe; high level selects serial mode |
| par_m | input | 9 | Parallel feedback divider word |
| par_n | input | 3 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Serial transfer strobe |
| mreset | input | 1 | Functional master reset of the divider chain |
| pll_sel | input | 1 | 1: synthesizer tick, 0: reference tick (bypass) |
| vco_tick | input | 1 | Synthesizer tick enable |
| ref_tick | input | 1 | Reference tick enable |
| cfg_m | output | 9 | Programmed feedback divider value |
| cfg_n | output | 3 | Programmed output divider code |
| cfg_t | output | 2 | Programmed test-select field |
| out0 | output | 1 | Primary divided output |
| out0_n | output | 1 | Complement of out0 |
| out1 | output | 1 | Secondary output, primary divided by 16 |
| out1_n | output | 1 | Complement of out1 |
| test_out | output | 1 | Test output |

## Verification
The bench builds the block with its default parameters: a 9-bit feedback word and a post-divider of 16. It holds `vco_tick` high on every cycle, so the toggle gap of `out0` equals the ratio directly, and it sweeps all eight output codes. A reference tick on every third cycle gives bypass gaps of 3 and 6 cycles and exercises the reference toggle source of the test output. With ratios 1 and 2 the secondary output has gaps of 16 and 32 cycles, which keeps the post-divider check within a short run.

// File: rtl/clksyn_pkg.sv
// Shared constants, test-select encoding and output ratio decode for the
// divider configuration block. Assumes a 3-bit output code and 2-bit test field.
package clksyn_pkg;
    localparam int N_W     = 3;
    localparam int T_W     = 2;
    localparam int RATIO_W = 5;

    typedef enum logic [T_W-1:0] {
        TSEL_SHIFT_LSB = 2'b00,
        TSEL_HIGH      = 2'b01,
        TSEL_REF       = 2'b10,
        TSEL_POST      = 2'b11
    } tsel_e;

    // Output code to ratio: codes 0..3 give 2..16, codes 4..7 give 1..8.
    function automatic logic [RATIO_W-1:0] div_ratio(input logic [N_W-1:0] code);
        logic [2:0] sh;
        sh = {1'b0, code[1:0]} + {2'b00, ~code[2]};
        return RATIO_W'(1) << sh;
    endfunction
endpackage

// File: rtl/clksyn_edge.sv
// Rising-edge detector for a vector of slow level inputs sampled on clk.
// Assumes each input is stable for at least one clk cycle per level.
module clksyn_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    // Remember the previous sample of each level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = lvl[i] & ~lvl_q[i];
    end
endmodule

// File: rtl/clksyn_cfg_regs.sv
// Serial shift register and the divider setting registers. A parallel rise
// has priority over a serial transfer in the same cycle. Assumes the strobes
// arrive as one-cycle rise pulses from the edge detector.
module clksyn_cfg_regs
    import clksyn_pkg::*;
#(
    parameter int M_WIDTH = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_rise,
    input  logic               ser_rise,
    input  logic               ser_mode,
    input  logic               ser_load,
    input  logic               ser_dat,
    input  logic [M_WIDTH-1:0] par_m,
    input  logic [N_W-1:0]     par_n,
    output logic [M_WIDTH-1:0] cfg_m,
    output logic [N_W-1:0]     cfg_n,
    output logic [T_W-1:0]     cfg_t,
    output logic               sr_lsb
);
    localparam int SR_W = T_W + N_W + M_WIDTH;

    logic [SR_W-1:0] sreg;

    // Shift one serial bit in at each serial clock rise, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg <= '0;
        else if (ser_rise) sreg <= {sreg[SR_W-2:0], ser_dat};
    end

    // Load the settings from the parallel bus or the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_m <= '0;
            cfg_n <= '0;
            cfg_t <= '0;
        end else if (par_rise) begin
            cfg_m <= par_m;
            cfg_n <= par_n;
        end else if (ser_mode && ser_load) begin
            {cfg_t, cfg_n, cfg_m} <= sreg;
        end
    end

    assign sr_lsb = sreg[0];
endmodule

// File: rtl/clksyn_div_chain.sv
// Output divider chain: the primary output toggles every ratio ticks, and the
// secondary output toggles once per POST_DIV primary toggles. clr is the
// functional master reset. Assumes ratio >= 1 and POST_DIV >= 2.
module clksyn_div_chain
    import clksyn_pkg::*;
#(
    parameter int POST_DIV = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick,
    input  logic [RATIO_W-1:0] ratio,
    output logic               out0,
    output logic               out1
);
    localparam int PW = (POST_DIV > 2) ? $clog2(POST_DIV) : 1;

    logic [RATIO_W-1:0] hcnt;
    logic [PW-1:0]      pcnt;
    logic               term;

    // The compare is >= so that a lower new ratio cannot overrun the count.
    assign term = tick && (hcnt >= (ratio - RATIO_W'(1)));

    // Primary half-period counter and output.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hcnt <= '0;
            out0 <= 1'b0;
        end else if (term) begin
            hcnt <= '0;
            out0 <= ~out0;
        end else if (tick) begin
            hcnt <= hcnt + RATIO_W'(1);
        end
    end

    // Post-divider counts primary toggles and toggles the secondary output.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt <= '0;
            out1 <= 1'b0;
        end else if (term) begin
            if (pcnt == PW'(POST_DIV - 1)) begin
                pcnt <= '0;
                out1 <= ~out1;
            end else begin
                pcnt <= pcnt + PW'(1);
            end
        end
    end
endmodule

// File: rtl/clksyn_divcfg.sv
// Top of the divider configuration block: strobe edge detection, setting
// registers, tick source select, output chain and test output select.
// Assumes all inputs are synchronous to clk or slow enough to be sampled.
module clksyn_divcfg
    import clksyn_pkg::*;
#(
    parameter int M_WIDTH  = 9,
    parameter int POST_DIV = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_load,
    input  logic [M_WIDTH-1:0] par_m,
    input  logic [N_W-1:0]     par_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_load,
    input  logic               mreset,
    input  logic               pll_sel,
    input  logic               vco_tick,
    input  logic               ref_tick,
    output logic [M_WIDTH-1:0] cfg_m,
    output logic [N_W-1:0]     cfg_n,
    output logic [T_W-1:0]     cfg_t,
    output logic               out0,
    output logic               out0_n,
    output logic               out1,
    output logic               out1_n,
    output logic               test_out
);
    logic [1:0] rise;
    logic       sr_lsb;
    logic       tick;
    logic       ref_div;

    clksyn_edge #(.W(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({ser_clk, par_load}),
        .rise  (rise)
    );

    clksyn_cfg_regs #(.M_WIDTH(M_WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_rise (rise[0]),
        .ser_rise (rise[1]),
        .ser_mode (par_load),
        .ser_load (ser_load),
        .ser_dat  (ser_dat),
        .par_m    (par_m),
        .par_n    (par_n),
        .cfg_m    (cfg_m),
        .cfg_n    (cfg_n),
        .cfg_t    (cfg_t),
        .sr_lsb   (sr_lsb)
    );

    assign tick = pll_sel ? vco_tick : ref_tick;

    clksyn_div_chain #(.POST_DIV(POST_DIV)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mreset),
        .tick  (tick),
        .ratio (div_ratio(cfg_n)),
        .out0  (out0),
        .out1  (out1)
    );

    // Reference toggle flop used as a test source.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset) ref_div <= 1'b0;
        else if (ref_tick)    ref_div <= ~ref_div;
    end

    assign out0_n = ~out0;
    assign out1_n = ~out1;

    // Test output source select; forced low in parallel mode.
    always_comb begin
        test_out = 1'b0;
        if (par_load) begin
            case (tsel_e'(cfg_t))
                TSEL_SHIFT_LSB: test_out = sr_lsb;
                TSEL_HIGH:      test_out = 1'b1;
                TSEL_REF:       test_out = ref_div;
                TSEL_POST:      test_out = out1;
                default:        test_out = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/clksyn_divcfg_chk.sv
// Protocol checker for clksyn_divcfg, attached by bind. Observes ports only.
module clksyn_divcfg_chk #(
    parameter int M_WIDTH = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               par_load,
    input logic [M_WIDTH-1:0] par_m,
    input logic [2:0]         par_n,
    input logic               ser_load,
    input logic               mreset,
    input logic [M_WIDTH-1:0] cfg_m,
    input logic [2:0]         cfg_n,
    input logic [1:0]         cfg_t,
    input logic               out0,
    input logic               out0_n,
    input logic               out1,
    input logic               out1_n,
    input logic               test_out
);
    p_par_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_load) |=> (cfg_m == $past(par_m)) && (cfg_n == $past(par_n)));

    p_t_serial_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(par_load && ser_load) |-> $stable(cfg_t));

    p_par_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!par_load) |-> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));

    p_post_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(out1) && !$past(mreset)) |-> !$stable(out0));

    p_mr_outs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mreset) |-> (!out0 && !out1 && out0_n && out1_n));

    p_test_par_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !par_load |-> !test_out);
endmodule

bind clksyn_divcfg clksyn_divcfg_chk #(.M_WIDTH(M_WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_load (par_load),
    .par_m    (par_m),
    .par_n    (par_n),
    .ser_load (ser_load),
    .mreset   (mreset),
    .cfg_m    (cfg_m),
    .cfg_n    (cfg_n),
    .cfg_t    (cfg_t),
    .out0     (out0),
    .out0_n   (out0_n),
    .out1     (out1),
    .out1_n   (out1_n),
    .test_out (test_out)
);

// File: tb/sim_clksyn_divcfg.sv
// Scoreboard bench: driver tasks queue expected items; the monitor pops one
// item per falling edge and compares it with the outputs.
module sim_clksyn_divcfg;
    localparam int MW = 9;
    localparam int PD = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0, par_load = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic          ser_load = 1'b0, mreset = 1'b0, pll_sel = 1'b1, vco_tick = 1'b1, ref_tick = 1'b0;
    logic [MW-1:0] par_m = '0;
    logic [2:0]    par_n = '0;
    logic [MW-1:0] cfg_m;
    logic [2:0]    cfg_n;
    logic [1:0]    cfg_t;
    logic          out0, out0_n, out1, out1_n, test_out;

    clksyn_divcfg #(.M_WIDTH(MW), .POST_DIV(PD)) u0 (
        .clk(clk), .rst_n(rst_n), .par_load(par_load), .par_m(par_m), .par_n(par_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load), .mreset(mreset),
        .pll_sel(pll_sel), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .out0(out0), .out0_n(out0_n),
        .out1(out1), .out1_n(out1_n), .test_out(test_out)
    );

    typedef enum int {K_CFG, K_OUTS, K_TEST, K_GAP0, K_GAP1, K_GAPT, K_TEQ1, K_COMP} kind_e;
    typedef struct {
        kind_e kind;
        string req;
        int    exp;
    } item_t;

    item_t q[$];
    item_t it;
    int    checks = 0, fails = 0, cyc = 0;
    int    last0 = 0, gap0 = 0, last1 = 0, gap1 = 0, lastt = 0, gapt = 0;
    logic  p0 = 1'b0, p1 = 1'b0, pt = 1'b0;
    logic [13:0] model = '0;
    bit    done = 0;
    int    exp_r[8] = '{2, 4, 8, 16, 1, 2, 4, 8};

    // Monitor: reference tick, toggle-gap tracking, and scoreboard compare.
    always @(negedge clk) begin
        int act;
        cyc++;
        ref_tick = ((cyc % 3) == 0);
        if (out0 !== p0)     begin gap0 = cyc - last0; last0 = cyc; p0 = out0; end
        if (out1 !== p1)     begin gap1 = cyc - last1; last1 = cyc; p1 = out1; end
        if (test_out !== pt) begin gapt = cyc - lastt; lastt = cyc; pt = test_out; end
        if (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                K_CFG:   act = int'({cfg_t, cfg_n, cfg_m});
                K_OUTS:  act = int'({out0, out0_n, out1, out1_n});
                K_TEST:  act = int'(test_out);
                K_GAP0:  act = gap0;
                K_GAP1:  act = gap1;
                K_GAPT:  act = gapt;
                K_TEQ1:  act = int'(test_out == out1);
                default: act = int'((out0_n == ~out0) && (out1_n == ~out1));
            endcase
            checks++;
            if (act != it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_item(input kind_e k, input string r, input int e);
        q.push_back('{k, r, e});
        wait_cyc(1);
    endtask

    function automatic int pack(input int m, input int n, input int t);
        return (t << 12) | (n << 9) | m;
    endfunction

    task automatic par_capture(input int m, input int n, input bit back_low);
        par_m = MW'(m);
        par_n = 3'(n);
        par_load = 1'b1;
        wait_cyc(1);
        if (back_low) begin
            par_load = 1'b0;
            wait_cyc(1);
        end
    endtask

    task automatic shift_bit(input bit b);
        ser_dat = b;
        ser_clk = 1'b1;
        wait_cyc(1);
        ser_clk = 1'b0;
        wait_cyc(1);
        model = {model[12:0], b};
    endtask

    task automatic shift_word(input int t, input int n, input int m);
        logic [13:0] w;
        w = 14'(pack(m, n, t));
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic sload_pulse();
        ser_load = 1'b1;
        wait_cyc(1);
        ser_load = 1'b0;
        wait_cyc(1);
    endtask

    task automatic mr_pulse();
        mreset = 1'b1;
        wait_cyc(2);
        mreset = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(1_000_000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    // Driver sequence.
    initial begin
        wait_cyc(3);
        // R11: reset state while rst_n is low
        expect_item(K_CFG,  "R11", 0);
        expect_item(K_OUTS, "R11", 4'b0101);
        expect_item(K_TEST, "R11", 0);
        mreset = 1'b1;
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: parallel capture, first pattern
        par_capture(9'h1A5, 5, 0);
        expect_item(K_CFG, "R1", pack(9'h1A5, 5, 0));
        // R4: level held high without a rise ignores bus changes
        par_m = 9'h0F0;
        par_n = 3'd2;
        wait_cyc(2);
        expect_item(K_CFG, "R4", pack(9'h1A5, 5, 0));
        par_load = 1'b0;
        wait_cyc(1);
        // R4: serial strobe ignored in parallel mode
        sload_pulse();
        expect_item(K_CFG, "R4", pack(9'h1A5, 5, 0));
        expect_item(K_TEST, "R10", 0);
        // R1: second pattern
        par_capture(9'h003, 2, 1);
        expect_item(K_CFG, "R1", pack(9'h003, 2, 0));
        // R8: outputs held and settings kept while mreset is high
        expect_item(K_OUTS, "R8", 4'b0101);
        expect_item(K_CFG,  "R8", pack(9'h003, 2, 0));

        // R5: every output code ratio, synthesizer tick each cycle
        mreset = 1'b0;
        for (int c = 0; c < 8; c++) begin
            par_capture(9'h011, c, 1);
            mr_pulse();
            wait_cyc(52);
            expect_item(K_GAP0, "R5", exp_r[c]);
            expect_item(K_COMP, "R7", 1);
        end

        // R6: secondary period, ratios 1 and 2
        par_capture(9'h011, 4, 1);
        mr_pulse();
        wait_cyc(52);
        expect_item(K_GAP1, "R6", 16);
        expect_item(K_COMP, "R7", 1);
        par_capture(9'h011, 5, 1);
        mr_pulse();
        wait_cyc(100);
        expect_item(K_GAP1, "R6", 32);

        // R8: master reset while running, then the chain resumes
        mreset = 1'b1;
        wait_cyc(1);
        expect_item(K_OUTS, "R8", 4'b0101);
        expect_item(K_CFG,  "R8", pack(9'h011, 5, 0));
        mreset = 1'b0;
        wait_cyc(10);
        expect_item(K_GAP0, "R8", 2);

        // R9: bypass uses the reference tick (every third cycle)
        pll_sel = 1'b0;
        par_capture(9'h011, 4, 1);
        mr_pulse();
        wait_cyc(12);
        expect_item(K_GAP0, "R9", 3);
        par_capture(9'h011, 0, 1);
        mr_pulse();
        wait_cyc(20);
        expect_item(K_GAP0, "R9", 6);
        pll_sel = 1'b1;

        // R2: serial word transferred into the fields
        par_capture(0, 0, 0);
        shift_word(1, 3, 9'h155);
        expect_item(K_CFG, "R4", pack(0, 0, 0));
        sload_pulse();
        expect_item(K_CFG,  "R2",  pack(9'h155, 3, 1));
        expect_item(K_TEST, "R10", 1);

        // R3: transparent while ser_load is high, then hold
        ser_load = 1'b1;
        shift_bit(1'b1);
        expect_item(K_CFG, "R3", int'(model));
        shift_bit(1'b0);
        expect_item(K_CFG, "R3", int'(model));
        ser_load = 1'b0;
        wait_cyc(1);
        begin
            int held;
            held = int'(model);
            shift_bit(1'b1);
            expect_item(K_CFG, "R3", held);
        end

        // R10: source 00 shows the last shifted bit
        shift_word(0, 1, 9'h0AA);
        sload_pulse();
        expect_item(K_CFG, "R2", pack(9'h0AA, 1, 0));
        shift_bit(1'b1);
        expect_item(K_TEST, "R10", 1);
        shift_bit(1'b0);
        expect_item(K_TEST, "R10", 0);

        // R10: source 10 shows the reference toggle flop
        shift_word(2, 4, 0);
        sload_pulse();
        wait_cyc(12);
        expect_item(K_GAPT, "R10", 3);

        // R10: source 11 shows the secondary output
        shift_word(3, 4, 0);
        sload_pulse();
        mr_pulse();
        wait_cyc(52);
        expect_item(K_GAPT, "R10", 16);
        expect_item(K_TEQ1, "R10", 1);
        wait_cyc(5);
        expect_item(K_TEQ1, "R10", 1);

        // R10: parallel mode forces the test output low
        par_load = 1'b0;
        wait_cyc(1);
        expect_item(K_TEST, "R10", 0);
        expect_item(K_CFG,  "R4",  pack(0, 4, 3));

        wait_cyc(2);
        finish_run();
    end
endmodule